// File: doc/BRIEF.md
# Two-Wire Register-Pointer Slave

This block is the serial front end that lets a bus master reach the register file of a monitoring chip over a two-wire, SMBus/I2C-style bus. The clock line and the data line are sampled through a synchroniser into a fast system clock. Start and stop conditions and clock edges are detected in that domain. The block acknowledges its own 7-bit device address and keeps an 8-bit address pointer. The data line is driven as an open-drain pull-down enable.

A write transaction always puts its first byte into the pointer. If a second byte follows, it goes to the register the pointer selects, through a single-cycle strobe on the register port. Any later bytes in the same write are acknowledged and discarded. A read transaction returns one byte, fetched from the register at the pointer. The pointer is never advanced automatically, so repeated reads return the same register. The device address is chosen by two strap pins and captured while reset is held.

Top module: `smb_regptr_slave`

## Requirements
- R1: Bus activity that follows a stop and has no new start is ignored. The block does not drive the data line and does not touch the pointer.
- R2: After a start, the first 8 bits are read MSB first as a 7-bit address followed by a direction bit (0 = write, 1 = read). On an address match, the block pulls the data line low for the whole high phase of the ninth clock. It changes the data line only while the clock line is low.
- R3: If the address does not match, nothing is acknowledged, the pointer is unchanged, no register is written, and the rest of the transaction is ignored.
- R4: The first byte of a write transaction is loaded into the pointer, and the pointer is output on the register address port. The pointer changes at no other time.
- R5: The second byte of a write produces exactly one single-cycle write strobe. During the strobe, the address is the pointer just loaded and the data is that byte.
- R6: Third and later bytes of a write are acknowledged, but they produce no strobe and leave the pointer unchanged.
- R7: A read shifts out the register data at the pointer, MSB first. A 1 bit releases the line and a 0 bit pulls it low. The line is released after the eighth bit. The pointer does not advance, so a second read returns the same byte.
- R8: While reset is held, the strap pins pick the device address. If the enable strap is high, the address is 7'h2E. If the enable strap is low, a select strap of 0 gives 7'h2C and a select strap of 1 gives 7'h2E. Strap changes after reset have no effect.
- R9: A repeated start without a stop begins a new address phase. This allows a pointer write followed by a read within one bus transaction.
- R10: Reset releases the data line, clears the pointer to 8'h00 and holds the write strobe low.
- R11: A write that carries only the pointer byte updates the pointer and produces no write strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Synchronous active-low reset; straps are sampled while it is low |
| strap_aen_n | input | 1 | Address-select enable strap, low selects by strap_sel |
| strap_sel | input | 1 | Address select strap: 0 gives 7'h2C, 1 gives 7'h2E |
| scl_i | input | 1 | Bus clock line as seen on the pad |
| sda_i | input | 1 | Bus data line as seen on the pad |
| sda_oe | output | 1 | Open-drain enable for the data line, 1 pulls low |
| reg_addr | output | 8 | Register address, equal to the pointer |
| reg_wr | output | 1 | Single-cycle register write strobe |
| reg_wdata | output | 8 | Register write data, valid with reg_wr |
| reg_rdata | input | 8 | Register read data for reg_addr, sampled when a read byte starts |

## Verification
On a single clock-line falling edge, the block both loads the pointer from the byte just received and starts pulling the data line low for the acknowledge. In a two-byte write, it also issues the register strobe within a few cycles of a pointer change. The bench provokes this overlap with back-to-back pointer-plus-data writes and with a pointer write followed by a repeated-start read. It checks the acknowledge in the ninth clock, compares the pointer with its own model on every idle clock, and checks that the captured strobe carries the newly loaded pointer rather than the old one.

// File: rtl/smb_pkg.sv
// Shared types for the two-wire register-pointer slave.
// Assumes: a single slave state machine, byte-wide transfers.
package smb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR,
        ST_WR_ACK,
        ST_RD,
        ST_RD_ACK
    } smb_state_t;

endpackage

// File: rtl/smb_line_sync.sv
// Multi-stage synchroniser for a group of bus lines, with one extra flop
// that gives the previous synchronised value for edge detection.
// Assumes: STAGES >= 2; the lines idle high, so reset loads ones.
module smb_line_sync #(
    parameter int STAGES = 2,
    parameter int LINES  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw,
    output logic [LINES-1:0] cur,
    output logic [LINES-1:0] prev
);

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain;
        logic              last;

        // Shift the raw line through the chain and keep one delayed copy.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain <= '1;
                last  <= 1'b1;
            end else begin
                chain <= {chain[STAGES-2:0], raw[g]};
                last  <= chain[STAGES-1];
            end
        end

        assign cur[g]  = chain[STAGES-1];
        assign prev[g] = last;
    end

endmodule

// File: rtl/smb_event_detect.sv
// Turns synchronised current/previous line values into single-cycle bus
// events: start, stop, clock rise and clock fall.
// Assumes: inputs come from smb_line_sync, one system clock apart.
module smb_event_detect (
    input  logic scl_c,
    input  logic scl_p,
    input  logic sda_c,
    input  logic sda_p,
    output logic start_evt,
    output logic stop_evt,
    output logic scl_rise,
    output logic scl_fall
);

    logic scl_held_high;

    // Classify the present line transitions.
    always_comb begin
        scl_held_high = scl_c && scl_p;
        start_evt     = scl_held_high && sda_p && !sda_c;
        stop_evt      = scl_held_high && !sda_p && sda_c;
        scl_rise      = scl_c && !scl_p;
        scl_fall      = !scl_c && scl_p;
    end

endmodule

// File: rtl/smb_addr_strap.sv
// Captures the device address from two strap pins while reset is held and
// keeps it until the next reset.
// Assumes: straps are static around the release of reset.
module smb_addr_strap #(
    parameter int                ADDR_W    = 7,
    parameter logic [ADDR_W-1:0] ADDR_SEL0 = 7'h2C,
    parameter logic [ADDR_W-1:0] ADDR_SEL1 = 7'h2E,
    parameter logic [ADDR_W-1:0] ADDR_DFLT = 7'h2E
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              aen_n,
    input  logic              sel,
    output logic [ADDR_W-1:0] dev_addr
);

    logic [ADDR_W-1:0] picked;

    // Decode the strap pins into a candidate address.
    always_comb begin
        if (aen_n)
            picked = ADDR_DFLT;
        else
            picked = sel ? ADDR_SEL1 : ADDR_SEL0;
    end

    // Follow the straps during reset, then freeze.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dev_addr <= picked;
        else
            dev_addr <= dev_addr;
    end

endmodule

// File: rtl/smb_ptr_reg.sv
// Holds the register pointer and produces the register-side write strobe.
// Assumes: rx_byte is stable in the cycle ptr_load or data_fire is high.
module smb_ptr_reg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ptr_load,
    input  logic              data_fire,
    input  logic [DATA_W-1:0] rx_byte,
    output logic [DATA_W-1:0] reg_addr,
    output logic              reg_wr,
    output logic [DATA_W-1:0] reg_wdata
);

    // Load the pointer and register the single-cycle write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_addr  <= '0;
            reg_wr    <= 1'b0;
            reg_wdata <= '0;
        end else begin
            reg_wr <= data_fire;
            if (ptr_load)
                reg_addr <= rx_byte;
            if (data_fire)
                reg_wdata <= rx_byte;
        end
    end

endmodule

// File: rtl/smb_slave_fsm.sv
// Byte-level protocol engine: receives the address and write bytes,
// drives acknowledges and read data, and flags pointer/data bytes.
// Assumes: the master changes the data line only while the clock is low,
// and the clock low phase lasts several system clocks.
module smb_slave_fsm
    import smb_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_evt,
    input  logic              stop_evt,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_s,
    input  logic [ADDR_W-1:0] dev_addr,
    input  logic [DATA_W-1:0] rd_byte,
    output logic              sda_oe,
    output logic              ptr_load,
    output logic              data_fire,
    output logic [DATA_W-1:0] rx_byte
);

    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam int IDX_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DATA_W);

    smb_state_t        state;
    logic [CNT_W-1:0]  bit_cnt;
    logic [DATA_W-1:0] shreg;
    logic [DATA_W-1:0] tx;
    logic [1:0]        wr_idx;
    logic              rw;
    logic              addr_hit;
    logic [IDX_W-1:0]  tx_idx;

    // Compare the received address bits and pick the next bit to send.
    always_comb begin
        addr_hit = (shreg[DATA_W-1 -: ADDR_W] == dev_addr);
        tx_idx   = IDX_W'(DATA_W - 1) - bit_cnt[IDX_W-1:0];
    end

    // Protocol state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            bit_cnt   <= '0;
            shreg     <= '0;
            tx        <= '0;
            wr_idx    <= '0;
            rw        <= 1'b0;
            sda_oe    <= 1'b0;
            ptr_load  <= 1'b0;
            data_fire <= 1'b0;
        end else begin
            ptr_load  <= 1'b0;
            data_fire <= 1'b0;
            if (start_evt) begin
                state   <= ST_ADDR;
                bit_cnt <= '0;
                wr_idx  <= '0;
                sda_oe  <= 1'b0;
            end else if (stop_evt) begin
                state   <= ST_IDLE;
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR, ST_WR: begin
                        if (scl_rise) begin
                            shreg   <= {shreg[DATA_W-2:0], sda_s};
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (scl_fall && bit_cnt == FULL) begin
                            bit_cnt <= '0;
                            if (state == ST_ADDR) begin
                                if (addr_hit) begin
                                    sda_oe <= 1'b1;
                                    rw     <= shreg[0];
                                    state  <= ST_ADDR_ACK;
                                end else begin
                                    state  <= ST_IDLE;
                                end
                            end else begin
                                sda_oe <= 1'b1;
                                state  <= ST_WR_ACK;
                                if (wr_idx == 2'd0)
                                    ptr_load <= 1'b1;
                                else if (wr_idx == 2'd1)
                                    data_fire <= 1'b1;
                                if (wr_idx != 2'd2)
                                    wr_idx <= wr_idx + 1'b1;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall) begin
                            bit_cnt <= '0;
                            if (rw) begin
                                state  <= ST_RD;
                                tx     <= rd_byte;
                                sda_oe <= ~rd_byte[DATA_W-1];
                            end else begin
                                state  <= ST_WR;
                                sda_oe <= 1'b0;
                            end
                        end
                    end
                    ST_WR_ACK: begin
                        if (scl_fall) begin
                            sda_oe <= 1'b0;
                            state  <= ST_WR;
                        end
                    end
                    ST_RD: begin
                        if (scl_rise) begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (scl_fall) begin
                            if (bit_cnt == FULL) begin
                                sda_oe  <= 1'b0;
                                bit_cnt <= '0;
                                state   <= ST_RD_ACK;
                            end else begin
                                sda_oe  <= ~tx[tx_idx];
                            end
                        end
                    end
                    ST_RD_ACK: begin
                        if (scl_rise)
                            state <= ST_IDLE;
                    end
                    default: begin
                        state <= ST_IDLE;
                    end
                endcase
            end
        end
    end

    assign rx_byte = shreg;

endmodule

// File: rtl/smb_regptr_slave.sv
// Top of the two-wire register-pointer slave: synchroniser, event
// detection, address strap, protocol engine and pointer register.
// Assumes: system clock at least ~8x faster than the bus clock.
module smb_regptr_slave #(
    parameter int               SYNC_STAGES = 2,
    parameter int               ADDR_W      = 7,
    parameter int               DATA_W      = 8,
    parameter logic [ADDR_W-1:0] ADDR_SEL0  = 7'h2C,
    parameter logic [ADDR_W-1:0] ADDR_SEL1  = 7'h2E,
    parameter logic [ADDR_W-1:0] ADDR_DFLT  = 7'h2E
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_aen_n,
    input  logic              strap_sel,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic [DATA_W-1:0] reg_addr,
    output logic              reg_wr,
    output logic [DATA_W-1:0] reg_wdata,
    input  logic [DATA_W-1:0] reg_rdata
);

    logic [1:0]        line_cur;
    logic [1:0]        line_prev;
    logic              scl_s;
    logic              sda_s;
    logic              start_evt;
    logic              stop_evt;
    logic              scl_rise;
    logic              scl_fall;
    logic [ADDR_W-1:0] dev_addr;
    logic              ptr_load;
    logic              data_fire;
    logic [DATA_W-1:0] rx_byte;

    smb_line_sync #(
        .STAGES (SYNC_STAGES),
        .LINES  (2)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   ({scl_i, sda_i}),
        .cur   (line_cur),
        .prev  (line_prev)
    );

    assign scl_s = line_cur[1];
    assign sda_s = line_cur[0];

    smb_event_detect u_evt (
        .scl_c     (line_cur[1]),
        .scl_p     (line_prev[1]),
        .sda_c     (line_cur[0]),
        .sda_p     (line_prev[0]),
        .start_evt (start_evt),
        .stop_evt  (stop_evt),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall)
    );

    smb_addr_strap #(
        .ADDR_W    (ADDR_W),
        .ADDR_SEL0 (ADDR_SEL0),
        .ADDR_SEL1 (ADDR_SEL1),
        .ADDR_DFLT (ADDR_DFLT)
    ) u_strap (
        .clk      (clk),
        .rst_n    (rst_n),
        .aen_n    (strap_aen_n),
        .sel      (strap_sel),
        .dev_addr (dev_addr)
    );

    smb_slave_fsm #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_evt (start_evt),
        .stop_evt  (stop_evt),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .sda_s     (sda_s),
        .dev_addr  (dev_addr),
        .rd_byte   (reg_rdata),
        .sda_oe    (sda_oe),
        .ptr_load  (ptr_load),
        .data_fire (data_fire),
        .rx_byte   (rx_byte)
    );

    smb_ptr_reg #(
        .DATA_W (DATA_W)
    ) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .ptr_load  (ptr_load),
        .data_fire (data_fire),
        .rx_byte   (rx_byte),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata)
    );

endmodule

// File: rtl/smb_regptr_checker.sv
// Protocol and register-port properties for smb_regptr_slave, attached
// to every instance by the bind statement at the end of this file.
// Assumes: the master respects the data-stable-while-clock-high rule.
module smb_regptr_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_s,
    input logic              start_evt,
    input logic              stop_evt,
    input logic              ptr_load,
    input logic              sda_oe,
    input logic              reg_wr,
    input logic [DATA_W-1:0] reg_addr
);

    // R2: the data line drive never changes while the clock stays high.
    p_oe_steady_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && $past(scl_s) && !$past(start_evt) && !$past(stop_evt))
        |-> $stable(sda_oe));

    // R5: the write strobe lasts exactly one cycle.
    p_wr_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> !reg_wr);

    // R5: the strobe falls inside a clock-low phase.
    p_wr_in_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |-> !scl_s);

    // R4: the pointer moves only after a pointer-byte completion.
    p_ptr_only_on_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(reg_addr) |-> $past(ptr_load));

    // R1: a stop always leaves the data line released.
    p_stop_releases_r1: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> !sda_oe);

endmodule

bind smb_regptr_slave smb_regptr_checker #(
    .DATA_W (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (scl_s),
    .start_evt (start_evt),
    .stop_evt  (stop_evt),
    .ptr_load  (ptr_load),
    .sda_oe    (sda_oe),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr)
);

// File: tb/tb_smb_regptr_slave.sv
// Bench for smb_regptr_slave: a behavioural bus master plus a per-clock
// model of the pointer and idle line state, with a queue of expected writes.
module tb_smb_regptr_slave;

    localparam int Q = 8;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       aen_n, sel;
    logic       scl_m, sda_m;
    logic       sda_oe;
    logic [7:0] reg_addr, reg_wdata, reg_rdata;
    logic       reg_wr;
    wire        sda_line = sda_m & ~sda_oe;

    int         checks = 0;
    int         fails  = 0;
    logic       busy;
    logic [7:0] exp_ptr;
    logic [15:0] wr_q[$];

    always #2 clk = ~clk;

    assign reg_rdata = reg_addr ^ 8'hA5;

    smb_regptr_slave dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .strap_aen_n (aen_n),
        .strap_sel   (sel),
        .scl_i       (scl_m),
        .sda_i       (sda_line),
        .sda_oe      (sda_oe),
        .reg_addr    (reg_addr),
        .reg_wr      (reg_wr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata)
    );

    // Capture strobes; when idle compare pointer and line against the model.
    always @(negedge clk) begin
        if (reg_wr) wr_q.push_back({reg_addr, reg_wdata});
        if (rst_n === 1'b1 && !busy) begin
            checks++;
            if (reg_addr !== exp_ptr || sda_oe !== 1'b0 || reg_wr !== 1'b0) begin
                fails++;
                if (fails < 20)
                    $display("FAIL R4/R1 idle model: addr=%h oe=%b wr=%b expected addr=%h oe=0 wr=0",
                             reg_addr, sda_oe, reg_wr, exp_ptr);
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic waitc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic bus_start();
        sda_m = 1'b1; waitc(Q);
        scl_m = 1'b1; waitc(Q);
        sda_m = 1'b0; waitc(Q);
        scl_m = 1'b0; waitc(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; waitc(Q);
        scl_m = 1'b1; waitc(Q);
        sda_m = 1'b1; waitc(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; waitc(Q);
            scl_m = 1'b1; waitc(Q);
            scl_m = 1'b0; waitc(Q);
        end
        sda_m = 1'b1; waitc(Q);
        scl_m = 1'b1; waitc(Q / 2);
        acked = sda_oe;
        waitc(Q / 2);
        scl_m = 1'b0; waitc(Q);
    endtask

    task automatic recv_byte(output logic [7:0] v);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; waitc(Q);
            scl_m = 1'b1; waitc(Q / 2);
            v[i] = sda_line;
            waitc(Q / 2);
            scl_m = 1'b0; waitc(Q);
        end
        sda_m = 1'b1; waitc(Q);
        scl_m = 1'b1; waitc(Q);
        scl_m = 1'b0; waitc(Q);
    endtask

    task automatic do_reset(input logic a, input logic s);
        busy  = 1'b1;
        rst_n = 1'b0;
        aen_n = a;
        sel   = s;
        scl_m = 1'b1;
        sda_m = 1'b1;
        waitc(6);
        rst_n = 1'b1;
        waitc(1);
        aen_n = ~a;
        sel   = ~s;
        exp_ptr = 8'h00;
        wr_q.delete();
        busy  = 1'b0;
        waitc(4);
    endtask

    task automatic end_txn();
        bus_stop();
        waitc(6);
        busy = 1'b0;
        waitc(10);
    endtask

    initial begin
        logic       ack;
        logic [7:0] v;

        // R10: reset state, default address strap (enable high gives 7'h2E).
        do_reset(1'b1, 1'b0);
        chk("R10 oe after reset", sda_oe, 0);
        chk("R10 pointer after reset", reg_addr, 8'h00);
        chk("R10 strobe after reset", reg_wr, 0);

        // R2 R4 R5: pointer plus one data byte.
        busy = 1'b1;
        bus_start();
        send_byte({7'h2E, 1'b0}, ack); chk("R2 address ack", ack, 1);
        send_byte(8'h10, ack);         chk("R4 pointer byte ack", ack, 1);
        send_byte(8'h5A, ack);         chk("R5 data byte ack", ack, 1);
        exp_ptr = 8'h10;
        end_txn();
        chk("R5 strobe count", wr_q.size(), 1);
        if (wr_q.size() > 0) chk("R5 strobe addr/data", wr_q[0], 16'h105A);
        wr_q.delete();

        // R11: pointer-only write.
        busy = 1'b1;
        bus_start();
        send_byte({7'h2E, 1'b0}, ack); chk("R2 address ack", ack, 1);
        send_byte(8'h33, ack);         chk("R11 pointer ack", ack, 1);
        exp_ptr = 8'h33;
        end_txn();
        chk("R11 no strobe", wr_q.size(), 0);
        chk("R11 pointer value", reg_addr, 8'h33);

        // R7: two reads return the same byte, MSB first.
        for (int n = 0; n < 2; n++) begin
            busy = 1'b1;
            bus_start();
            send_byte({7'h2E, 1'b1}, ack); chk("R7 read address ack", ack, 1);
            recv_byte(v);                  chk("R7 read data", v, 8'h33 ^ 8'hA5);
            end_txn();
            chk("R7 pointer not advanced", reg_addr, 8'h33);
        end

        // R3: wrong address is ignored.
        busy = 1'b1;
        bus_start();
        send_byte({7'h2C, 1'b0}, ack); chk("R3 no ack on mismatch", ack, 0);
        send_byte(8'h77, ack);         chk("R3 following byte ignored", ack, 0);
        send_byte(8'h99, ack);         chk("R3 data ignored", ack, 0);
        end_txn();
        chk("R3 no strobe", wr_q.size(), 0);

        // R6: extra write bytes acked and dropped.
        busy = 1'b1;
        bus_start();
        send_byte({7'h2E, 1'b0}, ack); chk("R2 address ack", ack, 1);
        send_byte(8'h40, ack);         chk("R4 pointer ack", ack, 1);
        send_byte(8'h11, ack);         chk("R5 data ack", ack, 1);
        send_byte(8'h22, ack);         chk("R6 third byte ack", ack, 1);
        send_byte(8'h33, ack);         chk("R6 fourth byte ack", ack, 1);
        exp_ptr = 8'h40;
        end_txn();
        chk("R6 one strobe only", wr_q.size(), 1);
        if (wr_q.size() > 0) chk("R6 strobe addr/data", wr_q[0], 16'h4011);
        wr_q.delete();

        // R9: pointer write, repeated start, read.
        busy = 1'b1;
        bus_start();
        send_byte({7'h2E, 1'b0}, ack); chk("R9 write address ack", ack, 1);
        send_byte(8'h55, ack);         chk("R9 pointer ack", ack, 1);
        bus_start();
        send_byte({7'h2E, 1'b1}, ack); chk("R9 restart address ack", ack, 1);
        recv_byte(v);                  chk("R9 read after restart", v, 8'h55 ^ 8'hA5);
        exp_ptr = 8'h55;
        end_txn();
        chk("R9 no strobe", wr_q.size(), 0);

        // R1: clocks after a stop with no start (idle model keeps checking).
        scl_m = 1'b0; waitc(Q);
        send_byte({7'h2E, 1'b0}, ack); chk("R1 no ack without start", ack, 0);
        send_byte(8'h66, ack);         chk("R1 byte ignored", ack, 0);
        bus_stop();
        waitc(10);
        chk("R1 pointer kept", reg_addr, 8'h55);
        chk("R1 no strobe", wr_q.size(), 0);

        // R8: enable low, select 0 gives 7'h2C; straps flipped after reset.
        do_reset(1'b0, 1'b0);
        busy = 1'b1;
        bus_start();
        send_byte({7'h2C, 1'b0}, ack); chk("R8 strap 2C ack", ack, 1);
        send_byte(8'h21, ack);         chk("R8 pointer ack", ack, 1);
        exp_ptr = 8'h21;
        end_txn();
        busy = 1'b1;
        bus_start();
        send_byte({7'h2E, 1'b0}, ack); chk("R8 2E rejected after flip", ack, 0);
        end_txn();

        // R8: enable low, select 1 gives 7'h2E.
        do_reset(1'b0, 1'b1);
        busy = 1'b1;
        bus_start();
        send_byte({7'h2C, 1'b1}, ack); chk("R8 2C rejected", ack, 0);
        end_txn();
        busy = 1'b1;
        bus_start();
        send_byte({7'h2E, 1'b1}, ack); chk("R8 strap 2E ack", ack, 1);
        recv_byte(v);                  chk("R8 read reset pointer", v, 8'hA5);
        end_txn();

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        busy = 1'b1;
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule